// File: doc/BRIEF.md
# Differential Bus Receiver Failsafe and Standby Controller

This block is the digital control core of a half-duplex differential line transceiver. Two window-comparator flags from the analog front end tell it whether the bus pair currently sits clearly above or clearly below the switching window. It turns those flags into a receive output that follows any valid level. When the bus stays inside the window for too long, which happens when the pair is open, shorted or idle, it forces the receive output high so that line noise is never taken as data.

On the transmit side it produces the pair drive controls from the data bit and the driver enable. A build parameter sets the level that a floating data input presents on the A output. When the driver and the receiver are both disabled, the block enters a low-power standby after a programmable settling time. In standby the failsafe timer is stopped. When either enable returns, the block waits out a programmable wake-up delay before any output is enabled again.

Top module: `bus_failsafe_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block reaches this state after that edge: `standby`=1, `drv_oe`=0, `drv_a`=0, `drv_b`=0, `rcv_oe`=0, `failsafe`=0. The stored bus level is high.
- R2: When the block is active and `rcv_en_n`=0, the bus is valid high with `cmp_hi`=1 and `cmp_lo`=0, which drives `rcv_out`=1 in the same cycle. It is valid low with `cmp_lo`=1 and `cmp_hi`=0, which drives `rcv_out`=0 in the same cycle.
- R3: The bus is invalid when neither flag or both flags are set. `failsafe` rises after exactly TIMEOUT_CYC consecutive active clock edges that sample an invalid bus, and it is still 0 after TIMEOUT_CYC-1 such edges. While `failsafe` is 1 and the bus is invalid, `rcv_out`=1.
- R4: While the bus is invalid and `failsafe` is 0, `rcv_out` holds the last valid level that was sampled.
- R5: A valid level sets `rcv_out` to that level in the same cycle, even while `failsafe` is 1. `failsafe` then drops after the next clock edge.
- R6: A single edge that samples a valid level restarts the count. After it, TIMEOUT_CYC-1 invalid edges leave `failsafe` at 0.
- R7: When `rcv_en_n`=1 or the block is not active, `rcv_oe`=0 and `rcv_out`=0.
- R8: When active and `drv_en`=1, `drv_oe`=1, `drv_a`=data and `drv_b`=inverse of data. When `drv_en`=0, all three outputs are 0.
- R9: When `tx_open`=1, the data used on the pair is the OPEN_LEVEL parameter (1 means A high), and `tx_data` is ignored.
- R10: Standby entry: if the first edge that samples `drv_en`=0 and `rcv_en_n`=1 is E0, `standby` rises after edge E0+ENTER_CYC. An enable seen during that interval returns the block to active at the next edge.
- R11: Wake-up: if the first edge in standby that samples an enable is W0, `standby` falls and outputs may be enabled after edge W0+WAKE_CYC. `failsafe` stays 0 through standby and wake-up, whatever the bus does.
- R12: When active and both flags are set, `illegal_err`=1 in the same cycle, and the bus is treated as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_hi | input | 1 | Comparator flag: bus clearly high |
| cmp_lo | input | 1 | Comparator flag: bus clearly low |
| tx_data | input | 1 | Transmit data bit |
| tx_open | input | 1 | 1 when the data input is floating |
| drv_en | input | 1 | Driver enable, active high |
| rcv_en_n | input | 1 | Receiver enable, active low |
| drv_oe | output | 1 | Pair driver output enable |
| drv_a | output | 1 | Level for the A line |
| drv_b | output | 1 | Level for the B line |
| rcv_oe | output | 1 | Receive output enable (0 means high impedance) |
| rcv_out | output | 1 | Receive data output |
| failsafe | output | 1 | Bus-invalid timeout has forced the output high |
| illegal_err | output | 1 | Both comparator flags are set together |
| standby | output | 1 | Low-power standby is in effect |

## Verification
The hardest state to reach is the edge exactly one count before the timeout, and an invalid run that a one-edge valid glitch splits just short of that count. Random bus traffic almost never produces an unbroken run of exactly that length. Directed sequences therefore build invalid runs of TIMEOUT_CYC-1 and TIMEOUT_CYC edges, with and without the glitch. Random phases then draw invalid-run lengths around the timeout, together with rare enable drops that cross the standby and wake-up boundaries while the bus is invalid.

// File: rtl/fsc_pkg.sv
// Shared types for the failsafe controller: power-sequencer states and bus
// level classes. Assumes the comparator flags are already synchronous to clk.
package fsc_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'd0,
        PM_SLEEPING = 2'd1,
        PM_ASLEEP   = 2'd2,
        PM_WAKING   = 2'd3
    } pm_state_t;

    typedef enum logic [1:0] {
        BUS_NONE  = 2'd0,
        BUS_HIGH  = 2'd1,
        BUS_LOW   = 2'd2,
        BUS_CLASH = 2'd3
    } bus_lvl_t;

    // Map the two window flags onto a bus level class.
    function automatic bus_lvl_t classify(input logic hi, input logic lo);
        bus_lvl_t r;
        case ({hi, lo})
            2'b10:   r = BUS_HIGH;
            2'b01:   r = BUS_LOW;
            2'b11:   r = BUS_CLASH;
            default: r = BUS_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fsc_power_seq.sv
// Power sequencer. It moves through active, settling, standby and waking
// states from the combined enable request, and counts the entry and wake-up
// delays in clock cycles.
// Assumes ENTER_CYC >= 1 and WAKE_CYC >= 1. Reset lands in standby.
module fsc_power_seq
    import fsc_pkg::*;
#(
    parameter int ENTER_CYC = 250,
    parameter int WAKE_CYC  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_en,
    output logic active,
    output logic standby
);

    localparam int PMAX = (ENTER_CYC > WAKE_CYC) ? ENTER_CYC : WAKE_CYC;
    localparam int PCW  = $clog2(PMAX + 1);
    localparam logic [PCW-1:0] ENTER_LAST = PCW'(ENTER_CYC - 1);
    localparam logic [PCW-1:0] WAKE_LAST  = PCW'(WAKE_CYC - 1);

    pm_state_t      state;
    logic [PCW-1:0] pcnt;

    // State and delay counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PM_ASLEEP;
            pcnt  <= '0;
        end else begin
            case (state)
                PM_ACTIVE: begin
                    if (!any_en) begin
                        state <= PM_SLEEPING;
                        pcnt  <= '0;
                    end
                end
                PM_SLEEPING: begin
                    if (any_en)                 state <= PM_ACTIVE;
                    else if (pcnt == ENTER_LAST) state <= PM_ASLEEP;
                    else                        pcnt  <= pcnt + 1'b1;
                end
                PM_ASLEEP: begin
                    if (any_en) begin
                        state <= PM_WAKING;
                        pcnt  <= '0;
                    end
                end
                default: begin
                    if (!any_en)                state <= PM_ASLEEP;
                    else if (pcnt == WAKE_LAST) state <= PM_ACTIVE;
                    else                        pcnt  <= pcnt + 1'b1;
                end
            endcase
        end
    end

    // State decode for the rest of the block.
    always_comb begin
        active  = (state == PM_ACTIVE);
        standby = (state == PM_ASLEEP) || (state == PM_WAKING);
    end

endmodule

// File: rtl/fsc_bus_timer.sv
// Bus-invalid timer and receive level path. It counts consecutive invalid
// samples while run is high, saturates at the timeout and flags failsafe.
// It keeps the last valid level and resolves the level to present.
// Assumes TIMEOUT_CYC >= 1. Outside run the count is held at zero.
module fsc_bus_timer
    import fsc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 31250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cmp_hi,
    input  logic cmp_lo,
    output logic fs_active,
    output logic rx_level,
    output logic clash
);

    localparam int TCW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TCW-1:0] TLIM = TCW'(TIMEOUT_CYC);

    bus_lvl_t       lvl;
    logic           invalid;
    logic [TCW-1:0] tcnt;
    logic           last_lvl;

    // Classify the comparator pair.
    always_comb begin
        lvl     = classify(cmp_hi, cmp_lo);
        invalid = (lvl == BUS_NONE) || (lvl == BUS_CLASH);
        clash   = (lvl == BUS_CLASH);
    end

    // Count unbroken invalid samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                tcnt <= '0;
        else if (!run || !invalid) tcnt <= '0;
        else if (tcnt != TLIM)     tcnt <= tcnt + 1'b1;
    end

    // Remember the most recent valid level seen while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                           last_lvl <= 1'b1;
        else if (run && (lvl == BUS_HIGH))    last_lvl <= 1'b1;
        else if (run && (lvl == BUS_LOW))     last_lvl <= 1'b0;
    end

    // Failsafe flag and level resolution; a valid level always wins.
    always_comb begin
        fs_active = (tcnt == TLIM);
        case (lvl)
            BUS_HIGH: rx_level = 1'b1;
            BUS_LOW:  rx_level = 1'b0;
            default:  rx_level = fs_active ? 1'b1 : last_lvl;
        endcase
    end

endmodule

// File: rtl/fsc_drv_path.sv
// Pair driver control. It substitutes the open-input level when the data pin
// floats, and drives A with the data and B with its inverse when enabled.
// Both lines are 0 when the driver is disabled.
module fsc_drv_path #(
    parameter bit OPEN_LEVEL = 1'b1
) (
    input  logic drv_go,
    input  logic tx_data,
    input  logic tx_open,
    output logic drv_oe,
    output logic drv_a,
    output logic drv_b
);

    logic open_lvl;
    logic tx_eff;

    // Pick the level that a floating data input takes.
    generate
        if (OPEN_LEVEL) begin : g_open_high
            assign open_lvl = 1'b1;
        end else begin : g_open_low
            assign open_lvl = 1'b0;
        end
    endgenerate

    // Form the complementary pair drive.
    always_comb begin
        tx_eff = tx_open ? open_lvl : tx_data;
        drv_oe = drv_go;
        drv_a  = drv_go & tx_eff;
        drv_b  = drv_go & ~tx_eff;
    end

endmodule

// File: rtl/bus_failsafe_ctrl.sv
// Top of the failsafe controller. It joins the power sequencer, the
// bus-invalid timer and the driver path, and gates the receive output with
// the receiver enable and the active state.
// Assumes all inputs are synchronous to clk.
module bus_failsafe_ctrl #(
    parameter int TIMEOUT_CYC = 31250,
    parameter int ENTER_CYC   = 250,
    parameter int WAKE_CYC    = 1000,
    parameter bit OPEN_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_hi,
    input  logic cmp_lo,
    input  logic tx_data,
    input  logic tx_open,
    input  logic drv_en,
    input  logic rcv_en_n,
    output logic drv_oe,
    output logic drv_a,
    output logic drv_b,
    output logic rcv_oe,
    output logic rcv_out,
    output logic failsafe,
    output logic illegal_err,
    output logic standby
);

    logic any_en;
    logic active;
    logic fs_active;
    logic rx_level;
    logic clash;

    // Either enable is a request to be awake.
    assign any_en = drv_en | ~rcv_en_n;

    fsc_power_seq #(
        .ENTER_CYC (ENTER_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) pseq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_en  (any_en),
        .active  (active),
        .standby (standby)
    );

    fsc_bus_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) btmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .cmp_hi    (cmp_hi),
        .cmp_lo    (cmp_lo),
        .fs_active (fs_active),
        .rx_level  (rx_level),
        .clash     (clash)
    );

    fsc_drv_path #(
        .OPEN_LEVEL (OPEN_LEVEL)
    ) drv_i (
        .drv_go  (active & drv_en),
        .tx_data (tx_data),
        .tx_open (tx_open),
        .drv_oe  (drv_oe),
        .drv_a   (drv_a),
        .drv_b   (drv_b)
    );

    // Receive output gating and status outputs.
    always_comb begin
        rcv_oe      = active & ~rcv_en_n;
        rcv_out     = rcv_oe & rx_level;
        failsafe    = fs_active;
        illegal_err = active & clash;
    end

endmodule

// File: rtl/fsc_checker.sv
// Property checker for bus_failsafe_ctrl, attached through bind below.
module fsc_checker (
    input logic clk,
    input logic rst_n,
    input logic cmp_hi,
    input logic cmp_lo,
    input logic drv_en,
    input logic rcv_en_n,
    input logic drv_oe,
    input logic drv_a,
    input logic drv_b,
    input logic rcv_oe,
    input logic rcv_out,
    input logic failsafe,
    input logic standby
);

    // R3: failsafe only follows an edge that sampled an invalid bus.
    p_fs_after_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        failsafe |-> $past(!(cmp_hi ^ cmp_lo)));

    // R3: failsafe with an invalid bus shows high on an enabled output.
    p_fs_forces_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (failsafe && rcv_oe && !(cmp_hi ^ cmp_lo)) |-> rcv_out);

    // R5: a valid level ends failsafe at the next edge.
    p_fs_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (failsafe && (cmp_hi ^ cmp_lo)) |=> !failsafe);

    // R8: an enabled pair is always complementary.
    p_pair_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_oe |-> (drv_a != drv_b));

    // R10: standby only begins after both enables were off.
    p_stby_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> $past(!drv_en && rcv_en_n));

    // R11: standby only ends with an enable requested.
    p_wake_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby) |-> $past(drv_en || !rcv_en_n));

    // R11: nothing enabled and no failsafe while in standby.
    p_stby_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!drv_oe && !rcv_oe && !failsafe));

endmodule

bind bus_failsafe_ctrl fsc_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_hi   (cmp_hi),
    .cmp_lo   (cmp_lo),
    .drv_en   (drv_en),
    .rcv_en_n (rcv_en_n),
    .drv_oe   (drv_oe),
    .drv_a    (drv_a),
    .drv_b    (drv_b),
    .rcv_oe   (rcv_oe),
    .rcv_out  (rcv_out),
    .failsafe (failsafe),
    .standby  (standby)
);

// File: tb/bus_failsafe_ctrl_tb_top.sv
// Self-checking bench: directed corner cases followed by seeded random traffic,
// compared every cycle against a requirement-level model.
module bus_failsafe_ctrl_tb_top;

    localparam int TO   = 40;
    localparam int EN   = 4;
    localparam int WK   = 8;
    localparam bit OPEN = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_hi = 1'b0, cmp_lo = 1'b0, tx_data = 1'b0, tx_open = 1'b0;
    logic drv_en = 1'b0, rcv_en_n = 1'b1;
    logic drv_oe, drv_a, drv_b, rcv_oe, rcv_out, failsafe, illegal_err, standby;

    always #4 clk = ~clk;

    bus_failsafe_ctrl #(
        .TIMEOUT_CYC (TO), .ENTER_CYC (EN), .WAKE_CYC (WK), .OPEN_LEVEL (OPEN)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cmp_hi (cmp_hi), .cmp_lo (cmp_lo),
        .tx_data (tx_data), .tx_open (tx_open), .drv_en (drv_en),
        .rcv_en_n (rcv_en_n), .drv_oe (drv_oe), .drv_a (drv_a), .drv_b (drv_b),
        .rcv_oe (rcv_oe), .rcv_out (rcv_out), .failsafe (failsafe),
        .illegal_err (illegal_err), .standby (standby)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string tag    = "R1";

    // Model state: mode 0 active, 1 settling, 2 standby, 3 waking.
    int m_mode = 2, m_pc = 0, m_t = 0;
    bit m_last = 1'b1;

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model over one clock edge with the inputs it sampled.
    task automatic model_step();
        bit any, vh, vl, inv;
        int om;
        if (!rst_n) begin
            m_mode = 2; m_pc = 0; m_t = 0; m_last = 1'b1;
            return;
        end
        any = drv_en | ~rcv_en_n;
        vh  = cmp_hi & ~cmp_lo;
        vl  = cmp_lo & ~cmp_hi;
        inv = !(vh | vl);
        om  = m_mode;
        if (om == 0) begin
            if (inv) begin if (m_t < TO) m_t++; end
            else m_t = 0;
            if (vh) m_last = 1'b1;
            if (vl) m_last = 1'b0;
        end else m_t = 0;
        case (om)
            0: if (!any) begin m_mode = 1; m_pc = 0; end
            1: if (any) m_mode = 0; else if (m_pc == EN - 1) m_mode = 2; else m_pc++;
            2: if (any) begin m_mode = 3; m_pc = 0; end
            default: if (!any) m_mode = 2; else if (m_pc == WK - 1) m_mode = 0; else m_pc++;
        endcase
    endtask

    // Expected outputs {standby,drv_oe,a,b,rcv_oe,rcv_out,failsafe,illegal}.
    function automatic logic [7:0] expect_out();
        bit act, vh, vl, fs, roe, lvl, eff, doe;
        act = (m_mode == 0);
        vh  = cmp_hi & ~cmp_lo;
        vl  = cmp_lo & ~cmp_hi;
        fs  = (m_t == TO);
        roe = act & ~rcv_en_n;
        lvl = vh ? 1'b1 : (vl ? 1'b0 : (fs ? 1'b1 : m_last));
        eff = tx_open ? OPEN : tx_data;
        doe = act & drv_en;
        return {(m_mode == 2 || m_mode == 3), doe, doe & eff, doe & ~eff,
                roe, roe & lvl, fs, act & cmp_hi & cmp_lo};
    endfunction

    task automatic cmp_all();
        logic [7:0] a, e;
        a = {standby, drv_oe, drv_a, drv_b, rcv_oe, rcv_out, failsafe, illegal_err};
        e = expect_out();
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b at %0t", tag, a, e, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model_step();
            cmp_all();
        end
    endtask

    task automatic bus(input logic h, input logic l);
        cmp_hi = h; cmp_lo = l;
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        cyc(3);
        chk("R1 standby", standby, 1'b1);
        chk("R1 drv_oe", drv_oe, 1'b0);
        chk("R1 rcv_oe", rcv_oe, 1'b0);
        chk("R1 failsafe", failsafe, 1'b0);
        rst_n = 1'b1;

        // R11: wake-up sequencing
        tag = "R11"; rcv_en_n = 1'b0; bus(1, 0);
        cyc(WK);
        chk("R11 still asleep", standby, 1'b1);
        chk("R11 rcv_oe off while waking", rcv_oe, 1'b0);
        cyc(1);
        chk("R11 awake", standby, 1'b0);
        chk("R2 valid high", rcv_out, 1'b1);

        // R2: valid low
        tag = "R2"; bus(0, 1);
        cyc(1);
        chk("R2 valid low", rcv_out, 1'b0);

        // R3/R4: timeout boundary
        tag = "R3"; bus(0, 0);
        cyc(TO - 1);
        chk("R3 no failsafe at count-1", failsafe, 1'b0);
        chk("R4 holds last low", rcv_out, 1'b0);
        cyc(1);
        chk("R3 failsafe at count", failsafe, 1'b1);
        chk("R3 forced high", rcv_out, 1'b1);

        // R5: immediate recovery
        tag = "R5"; bus(0, 1);
        #1 chk("R5 same-cycle follow", rcv_out, 1'b0);
        cyc(1);
        chk("R5 failsafe cleared", failsafe, 1'b0);

        // R6: one-edge glitch restarts the count
        tag = "R6"; bus(0, 0);
        cyc(TO - 2);
        bus(1, 0);
        cyc(1);
        bus(0, 0);
        cyc(TO - 1);
        chk("R6 no failsafe after glitch", failsafe, 1'b0);
        chk("R6 holds glitch level", rcv_out, 1'b1);
        cyc(1);
        chk("R6 failsafe after full run", failsafe, 1'b1);

        // R12: clashing flags
        tag = "R12"; bus(1, 1);
        #1 chk("R12 illegal flag", illegal_err, 1'b1);
        chk("R12 treated invalid", rcv_out, 1'b1);
        cyc(1);
        chk("R12 failsafe kept", failsafe, 1'b1);

        // R8/R9: driver path
        tag = "R8"; bus(1, 0); drv_en = 1'b1; tx_data = 1'b0; tx_open = 1'b0;
        cyc(1);
        chk("R8 oe", drv_oe, 1'b1);
        chk("R8 a low", drv_a, 1'b0);
        chk("R8 b high", drv_b, 1'b1);
        tx_data = 1'b1;
        cyc(1);
        chk("R8 a high", drv_a, 1'b1);
        tag = "R9"; tx_open = 1'b1; tx_data = 1'b0;
        cyc(1);
        chk("R9 open level on A", drv_a, OPEN);
        chk("R9 open level on B", drv_b, ~OPEN);
        tx_open = 1'b0;

        // R7: receiver disabled
        tag = "R7"; rcv_en_n = 1'b1;
        cyc(1);
        chk("R7 rcv_oe off", rcv_oe, 1'b0);
        chk("R7 rcv_out low", rcv_out, 1'b0);

        // R10: aborted and completed standby entry
        tag = "R10"; drv_en = 1'b0;
        cyc(EN);
        chk("R10 settling not standby", standby, 1'b0);
        drv_en = 1'b1;
        cyc(1);
        chk("R10 abort back to active", drv_oe, 1'b1);
        drv_en = 1'b0;
        cyc(EN);
        chk("R10 before entry", standby, 1'b0);
        cyc(1);
        chk("R10 entered", standby, 1'b1);

        // R11: timer idle in standby and through wake-up
        tag = "R11"; bus(0, 0);
        cyc(TO + 5);
        chk("R11 no failsafe asleep", failsafe, 1'b0);
        rcv_en_n = 1'b0;
        cyc(WK + 1);
        chk("R11 awake", standby, 1'b0);
        chk("R11 timer restarted", failsafe, 1'b0);

        // Random traffic with invalid runs around the timeout.
        tag = "RND";
        begin
            int seed = $urandom(32'h5A17);
            int run_left = 0;
            int kind = 0;
            seed = seed;
            for (int k = 0; k < 4000; k++) begin
                if (run_left == 0) begin
                    kind = $urandom_range(0, 3);
                    run_left = (kind == 0 || kind == 3) ? $urandom_range(TO - 3, TO + 3)
                                                        : $urandom_range(1, 6);
                end
                run_left--;
                case (kind)
                    0: bus(0, 0);
                    1: bus(1, 0);
                    2: bus(0, 1);
                    default: bus($urandom_range(0, 9) == 0, 1'b0);
                endcase
                tx_data = 1'($urandom_range(0, 1));
                tx_open = ($urandom_range(0, 7) == 0);
                if ($urandom_range(0, 150) == 0) drv_en = ~drv_en;
                if ($urandom_range(0, 120) == 0) rcv_en_n = ~rcv_en_n;
                cyc(1);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule